// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block is a small direct-mapped read cache that stands between a processor load port and a beat-oriented memory port. On a hit it returns the word one cycle after the request. On a miss it asks memory for the whole line and then stores each returned beat at the word slot named by the beat's index. It releases the processor as soon as the beat that carries the requested word is captured, and the rest of the line keeps filling after that.

The `WRAP` parameter picks the fetch order. With `WRAP=1`, memory is asked to start at the missed word and wrap around the line, so the processor waits the same time whatever the word offset. With `WRAP=0`, memory is always asked to start at word 0 and count upward, and the processor is released when its own word goes past. A line is marked valid only after its last beat is written. While a fill is running, a request to a word of that line that has already been written is served. Any other request waits until the fill is done.

The processor holds `cpu_req` and `cpu_addr` steady until it sees `cpu_rvalid`. Memory answers a `mem_req` pulse with one beat per cycle, after any fixed latency, in wrap-around order from `mem_first`.

Top module: `cwf_refill`

## Requirements
- R1: After reset, `cpu_rvalid` and `mem_req` are low.
- R2: A request to a valid line whose tag matches returns the stored word with `cpu_rvalid` one cycle after the request is first seen, and no memory request is made.
- R3: A miss makes exactly one single-cycle `mem_req` pulse carrying the line address. `mem_first` equals the missed word offset (the low `log2(WORDS)` address bits) when `WRAP=1`, and 0 when `WRAP=0`.
- R4: With `WRAP=1`, `cpu_rvalid` rises in the cycle after the first beat of the fill is captured, whatever the word offset.
- R5: With `WRAP=0`, `cpu_rvalid` rises in the cycle after the beat whose index equals the missed offset is captured, so the wait grows by one cycle per offset.
- R6: The word returned on a miss equals the data of the beat that carried it.
- R7: The line becomes valid only after its last beat is written. A request to a word of the filling line that is not yet written is held until the fill completes, and is then served as a hit.
- R8: During a fill, once the missed word has been returned, a request to an already-written word of the same line is served one cycle later.
- R9: A request to a different line during a fill is held until the fill completes, and is then handled as a new access.
- R10: After a fill, every word of the line reads back as the data memory returned for that word.
- R11: A request to the same index with a different tag is a miss. It refills the slot, and the old line is no longer hit.
- R12: No new `mem_req` is issued while beats of the previous fill are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request, held until `cpu_rvalid` |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_rvalid | output | 1 | One-cycle strobe: `cpu_rdata` is valid |
| cpu_rdata | output | DATA_W | Returned word |
| mem_req | output | 1 | One-cycle line fetch request |
| mem_line | output | ADDR_W-log2(WORDS) | Line address of the fetch |
| mem_first | output | log2(WORDS) | Word index memory must return first |
| mem_bvalid | input | 1 | A beat is present |
| mem_bidx | input | log2(WORDS) | Word index of the beat |
| mem_bdata | input | DATA_W | Beat data |

## Verification
The bench builds two copies side by side with the default geometry (4 words of 32 bits, 8 lines, 12-bit word address). One uses `WRAP=1` and the other `WRAP=0`, and each has its own memory model with a latency of 3 cycles. Having both orders in one run lets the release delay be compared for all four word offsets: flat in one copy and growing in the other. The small line count makes index conflicts easy to create. The short line also means the overlapped cases (a filled-word hit, an unfilled-word stall and a different-line stall in the middle of a fill) can be timed to the exact cycle.

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter bit WRAP   = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cpu_req,
  input  logic [ADDR_W-1:0]                   cpu_addr,
  output logic                                cpu_rvalid,
  output logic [DATA_W-1:0]                   cpu_rdata,
  output logic                                mem_req,
  output logic [ADDR_W-$clog2(WORDS)-1:0]     mem_line,
  output logic [$clog2(WORDS)-1:0]            mem_first,
  input  logic                                mem_bvalid,
  input  logic [$clog2(WORDS)-1:0]            mem_bidx,
  input  logic [DATA_W-1:0]                   mem_bdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - IDX_W;

  logic [DATA_W-1:0] arr [LINES*WORDS];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINES-1:0]  line_ok;

  logic              busy, f_sent;
  logic [LA_W-1:0]   f_line;
  logic [OFF_W-1:0]  f_crit;
  logic [WORDS-1:0]  f_have;

  wire [OFF_W-1:0] req_off = cpu_addr[OFF_W-1:0];
  wire [IDX_W-1:0] req_idx = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  wire [TAG_W-1:0] req_tag = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
  wire [LA_W-1:0]  req_la  = cpu_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0] f_idx   = f_line[IDX_W-1:0];

  wire [WORDS-1:0] beat_bit  = WORDS'(1) << mem_bidx;
  wire [WORDS-1:0] have_next = f_have | beat_bit;
  wire beat      = busy && mem_bvalid;
  wire last_beat = beat && (&have_next);
  wire crit_beat = beat && !f_sent && (mem_bidx == f_crit);

  wire hit_idle = !busy && cpu_req && line_ok[req_idx] && (tag_q[req_idx] == req_tag);
  wire hit_fill = busy && f_sent && cpu_req && (req_la == f_line) && f_have[req_off];
  wire miss     = !busy && cpu_req && !hit_idle;

  always_ff @(posedge clk) begin
    if (beat) arr[{f_idx, mem_bidx}] <= mem_bdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_line   <= '0;
      mem_first  <= '0;
      busy       <= 1'b0;
      f_sent     <= 1'b0;
      f_line     <= '0;
      f_crit     <= '0;
      f_have     <= '0;
      line_ok    <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      mem_req    <= 1'b0;
      if (crit_beat) begin
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= mem_bdata;
      end else if (hit_idle || hit_fill) begin
        cpu_rvalid <= 1'b1;
        cpu_rdata  <= arr[{req_idx, req_off}];
      end
      if (miss) begin
        mem_req          <= 1'b1;
        mem_line         <= req_la;
        mem_first        <= WRAP ? req_off : OFF_W'(0);
        busy             <= 1'b1;
        f_sent           <= 1'b0;
        f_line           <= req_la;
        f_crit           <= req_off;
        f_have           <= '0;
        line_ok[req_idx] <= 1'b0;
        tag_q[req_idx]   <= req_tag;
      end else begin
        if (beat) f_have <= have_next;
        if (crit_beat) f_sent <= 1'b1;
        if (last_beat) begin
          busy           <= 1'b0;
          line_ok[f_idx] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int WORDS = 4,
  parameter bit WRAP  = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cpu_req,
  input logic                     cpu_rvalid,
  input logic                     mem_req,
  input logic [$clog2(WORDS)-1:0] mem_first,
  input logic                     mem_bvalid
);
  localparam int CNT_W = $clog2(WORDS + 1);

  logic             wait_first;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_first <= 1'b0;
      left       <= '0;
    end else begin
      if (mem_req) begin
        wait_first <= 1'b1;
        left       <= CNT_W'(WORDS);
      end else if (mem_bvalid) begin
        wait_first <= 1'b0;
        if (left != 0) left <= left - 1'b1;
      end
    end
  end

  // R3
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R3
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRAP && mem_req) |-> (mem_first == '0));

  // R3
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(cpu_req));

  // R4
  wrap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WRAP && wait_first && mem_bvalid) |=> cpu_rvalid);

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (left == '0));
endmodule

bind cwf_refill cwf_refill_chk #(.WORDS(WORDS), .WRAP(WRAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_rvalid(cpu_rvalid),
  .mem_req(mem_req), .mem_first(mem_first), .mem_bvalid(mem_bvalid));

// File: tb/cwf_refill_tb_top.sv
`timescale 1ns/1ps
module tb_mem #(parameter int LAT = 3) (
  input  logic        clk,
  input  logic        req,
  input  logic [9:0]  line,
  input  logic [1:0]  first,
  output logic        bvalid,
  output logic [1:0]  bidx,
  output logic [31:0] bdata
);
  function automatic logic [31:0] wordval(input logic [9:0] la, input logic [1:0] off);
    return ({20'h0, la, off} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  initial begin
    bvalid = 1'b0; bidx = '0; bdata = '0;
    forever begin
      @(negedge clk);
      bvalid = 1'b0;
      if (req) begin
        logic [9:0] la;
        logic [1:0] f;
        la = line; f = first;
        repeat (LAT) @(negedge clk);
        for (int j = 0; j < 4; j++) begin
          if (j > 0) @(negedge clk);
          bvalid = 1'b1;
          bidx   = f + 2'(j);
          bdata  = wordval(la, f + 2'(j));
        end
      end
    end
  end
endmodule

module cwf_refill_tb_top;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req   [2];
  logic [11:0] addr  [2];
  logic        rv    [2];
  logic [31:0] rdat  [2];
  logic        mreq  [2];
  logic [9:0]  mline [2];
  logic [1:0]  mfirst[2];
  logic        bv    [2];
  logic [1:0]  bidx  [2];
  logic [31:0] bdat  [2];

  int nchk = 0, nfail = 0;
  int nreq [2];
  logic [1:0] lastfirst [2];

  cwf_refill #(.WRAP(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_addr(addr[1]),
    .cpu_rvalid(rv[1]), .cpu_rdata(rdat[1]), .mem_req(mreq[1]), .mem_line(mline[1]),
    .mem_first(mfirst[1]), .mem_bvalid(bv[1]), .mem_bidx(bidx[1]), .mem_bdata(bdat[1]));

  cwf_refill #(.WRAP(1'b0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_addr(addr[0]),
    .cpu_rvalid(rv[0]), .cpu_rdata(rdat[0]), .mem_req(mreq[0]), .mem_line(mline[0]),
    .mem_first(mfirst[0]), .mem_bvalid(bv[0]), .mem_bidx(bidx[0]), .mem_bdata(bdat[0]));

  tb_mem #(.LAT(LAT)) mem1_i (.clk(clk), .req(mreq[1]), .line(mline[1]), .first(mfirst[1]),
    .bvalid(bv[1]), .bidx(bidx[1]), .bdata(bdat[1]));
  tb_mem #(.LAT(LAT)) mem0_i (.clk(clk), .req(mreq[0]), .line(mline[0]), .first(mfirst[0]),
    .bvalid(bv[0]), .bidx(bidx[0]), .bdata(bdat[0]));

  initial begin nreq[0] = 0; nreq[1] = 0; lastfirst[0] = '0; lastfirst[1] = '0; end
  always @(negedge clk) if (mreq[0]) begin nreq[0]++; lastfirst[0] = mfirst[0]; end
  always @(negedge clk) if (mreq[1]) begin nreq[1]++; lastfirst[1] = mfirst[1]; end

  function automatic logic [31:0] wordval(input logic [11:0] a);
    return ({20'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [11:0] mk(input int tag, input int idx, input int off);
    return {7'(tag), 3'(idx), 2'(off)};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic rd(input int m, input logic [11:0] a, output int cyc, output logic [31:0] d);
    req[m] = 1'b1; addr[m] = a; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rv[m] && cyc < 200);
    d = rdat[m]; req[m] = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rvalid wrap", 32'(rv[1]), 0);
    chk("R1 rvalid seq", 32'(rv[0]), 0);
    chk("R1 mem_req wrap", 32'(mreq[1]), 0);
    chk("R1 mem_req seq", 32'(mreq[0]), 0);
  endtask

  task automatic t_latency(input int m);
    int cyc, n0; logic [31:0] d; logic [11:0] a;
    for (int off = 0; off < 4; off++) begin
      a = mk(m*8 + off + 1, off, off);
      n0 = nreq[m];
      rd(m, a, cyc, d);
      if (m == 1) chk("R4 wrap release delay", cyc, LAT + 2);
      else        chk("R5 seq release delay", cyc, LAT + 2 + off);
      chk("R6 forwarded data", d, wordval(a));
      settle();
      chk("R3 one request per miss", nreq[m] - n0, 1);
      chk("R3 start offset", 32'(lastfirst[m]), (m == 1) ? off : 0);
      for (int w = 0; w < 4; w++) begin
        logic [11:0] b;
        b = {a[11:2], 2'(w)};
        n0 = nreq[m];
        rd(m, b, cyc, d);
        chk("R2 hit delay", cyc, 1);
        chk("R10 line contents", d, wordval(b));
        chk("R2 no fetch on hit", nreq[m] - n0, 0);
      end
    end
  endtask

  task automatic t_fill_hit();
    int cyc; logic [31:0] d; logic [11:0] a;
    a = mk(50, 5, 1);
    rd(0, a, cyc, d);
    chk("R5 seq release offset 1", cyc, LAT + 3);
    rd(0, mk(50, 5, 0), cyc, d);
    chk("R8 filled word hit in fill", cyc, 1);
    chk("R8 filled word data", d, wordval(mk(50, 5, 0)));
    rd(0, mk(50, 5, 3), cyc, d);
    chk("R7 unfilled word held", cyc, 2);
    chk("R7 unfilled word data", d, wordval(mk(50, 5, 3)));
    settle();
  endtask

  task automatic t_other_line();
    int cyc, n0; logic [31:0] d;
    n0 = nreq[1];
    rd(1, mk(51, 6, 2), cyc, d);
    chk("R4 wrap release offset 2", cyc, LAT + 2);
    rd(1, mk(52, 7, 1), cyc, d);
    chk("R9 other line held", cyc, LAT + 5);
    chk("R9 other line data", d, wordval(mk(52, 7, 1)));
    settle();
    chk("R9 two fetches", nreq[1] - n0, 2);
  endtask

  task automatic t_conflict(input int m);
    int cyc; logic [31:0] d; logic [11:0] old_a, new_a;
    old_a = mk(m*8 + 1, 0, 0);
    new_a = mk(60, 0, 2);
    rd(m, new_a, cyc, d);
    chk("R11 conflict miss delay", cyc, (m == 1) ? LAT + 2 : LAT + 4);
    chk("R11 conflict data", d, wordval(new_a));
    settle();
    rd(m, old_a, cyc, d);
    chk("R11 evicted line misses", cyc, LAT + 2);
    chk("R11 evicted line data", d, wordval(old_a));
    settle();
    rd(m, old_a, cyc, d);
    chk("R11 refetched line hits", cyc, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    req[0] = 1'b0; req[1] = 1'b0; addr[0] = '0; addr[1] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_latency(1);
    t_latency(0);
    t_fill_hit();
    t_other_line();
    t_conflict(1);
    t_conflict(0);
    finish_run();
  end
endmodule